// File: doc/BRIEF.md
# Boundary Run-Test Operation Engine

This block carries out a built-in self-test operation on two groups of boundary cells: an input group and an output group, each `N_CELLS` wide (8 by default). It runs one step per rising test clock while the test access port controller sits in Run-Test/Idle under the run-test instruction. That condition arrives already decoded on `run_en`. A 3-bit operation code picks the step. Software loads the code serially through a dedicated control scan path: it shifts bits in while `ctl_shift` is high, then commits them to the active operation register with a pulse on `ctl_update`. Nothing is captured into this path, so its contents survive a Capture-DR pass untouched.

The cell groups are held in the engine and presented on `in_cells` and `out_cells`. A boundary-scan load on `cell_load` seeds both groups with a pattern. After a run, the groups keep their values while neither `run_en` nor `cell_load` is high, so a later boundary read can shift the signature out without changing it. Every interface here is a plain control or data pin sampled on the clock. There is no streaming traffic, so the block has no valid/ready handshake and applies no back-pressure.

Top module: `bist_run_engine`

## Requirements
- R1: After reset both cell groups are zero, `ctl_tdo` is 0, and the active operation is the hold code 111.
- R2: While `ctl_shift` is high, the control path shifts right each clock, taking `ctl_tdi` into bit 2, and `ctl_tdo` shows bit 0. A `ctl_update` pulse copies the shifted value into the active operation. The active operation never changes without an update, including while shifting.
- R3: When `run_en` and `cell_load` are both low, neither cell group changes.
- R4: Code 000 (sample/toggle): each run step loads `in_pins` into the input group and inverts every output cell.
- R5: Code 001 (pattern generation): the 16-bit value {out_cells, in_cells} steps as a left-shifting LFSR. The new bit 0 is the XOR of bits 15, 14, 12 and 3 (polynomial x^16+x^15+x^13+x^4+1).
- R6: Code 010 (signature analysis): the input group forms a multiple-input signature register. New bit 0 is in[7]^in[5]^in[4]^in[3]^pin[0]. New bit i (for i>0) is in[i-1]^pin[i]. The output group holds.
- R7: Code 011: the input group steps as in R6. On the same edge, the output group steps as an 8-bit left-shifting LFSR whose new bit 0 is out[7]^out[5]^out[4]^out[3].
- R8: Code 100: the input group steps as in R6. On the same edge, the output group increments by one and wraps from 255 to 0.
- R9: Codes 101, 110 and 111 leave both groups unchanged while running.
- R10: `cell_load` loads `load_in` and `load_out` into the groups on the next edge, taking priority over any running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; all state updates on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Controller is in Run-Test/Idle under the run-test instruction |
| ctl_shift | input | 1 | Control scan path selected and shifting |
| ctl_tdi | input | 1 | Serial data into the control path |
| ctl_update | input | 1 | Commit the control path to the active operation |
| ctl_tdo | output | 1 | Serial data out of the control path |
| cell_load | input | 1 | Parallel load of both cell groups |
| load_in | input | N_CELLS | Value loaded into the input group |
| load_out | input | N_CELLS | Value loaded into the output group |
| in_pins | input | N_CELLS | Device input pin values seen by the input cells |
| in_cells | output | N_CELLS | Current input cell group |
| out_cells | output | N_CELLS | Current output cell group |

## Verification
The bench runs every code, including the three unused ones, and pauses `run_en` in the middle of each run. A design that kept stepping during a pause would lose the signature that a boundary read expects. In the up-count mode it seeds the output group at 0xF0 so the counter passes the 255-to-0 wrap. An engine that saturated, or let the count carry into the input group, shows up at once. It also shifts a new code in while an operation is running and checks that the operation continues. A design that decoded the live shift bits would switch mode partway through the shift. Finally, it asserts `cell_load` together with `run_en` to catch an engine that lets the running step win over the load.

// File: rtl/bre_pkg.sv
package bre_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_TOGGLE   = 3'b000,
    OP_PRPG     = 3'b001,
    OP_PSA      = 3'b010,
    OP_PSA_PRPG = 3'b011,
    OP_PSA_CNT  = 3'b100,
    OP_IDLE     = 3'b111
  } op_e;

  typedef enum logic [1:0] {
    IN_HOLD, IN_SAMPLE, IN_MISR, IN_SHIFT
  } in_mode_e;

  typedef enum logic [2:0] {
    OUT_HOLD, OUT_TOGGLE, OUT_SHIFT, OUT_LFSR, OUT_COUNT
  } out_mode_e;
endpackage

// File: rtl/bre_ctl_scan.sv
module bre_ctl_scan
  import bre_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic            tdi,
  input  logic            update,
  output logic            tdo,
  output logic [OP_W-1:0] shift_q,
  output logic [OP_W-1:0] op_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      op_q    <= OP_IDLE;
    end else begin
      if (shift_en) shift_q <= {tdi, shift_q[OP_W-1:1]};
      if (update)   op_q    <= shift_q;
    end
  end

  assign tdo = shift_q[0];
endmodule

// File: rtl/bre_in_group.sv
module bre_in_group
  import bre_pkg::*;
#(
  parameter int           N    = 8,
  parameter logic [N-1:0] TAPS = 8'hB8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  in_mode_e     mode,
  input  logic         load,
  input  logic [N-1:0] load_val,
  input  logic [N-1:0] pins,
  input  logic         shift_in,
  output logic [N-1:0] cells
);
  logic [N-1:0] misr_nx;
  logic         misr_fb;
  logic [N-1:0] nx;

  assign misr_fb = ^(cells & TAPS);

  for (genvar i = 0; i < N; i++) begin : g_misr
    if (i == 0) begin : g_lsb
      assign misr_nx[i] = misr_fb ^ pins[i];
    end else begin : g_bit
      assign misr_nx[i] = cells[i-1] ^ pins[i];
    end
  end

  always_comb begin
    unique case (mode)
      IN_SAMPLE: nx = pins;
      IN_MISR:   nx = misr_nx;
      IN_SHIFT:  nx = {cells[N-2:0], shift_in};
      default:   nx = cells;
    endcase
    if (load) nx = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cells <= '0;
    else        cells <= nx;
  end
endmodule

// File: rtl/bre_out_group.sv
module bre_out_group
  import bre_pkg::*;
#(
  parameter int           N    = 8,
  parameter logic [N-1:0] TAPS = 8'hB8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  out_mode_e    mode,
  input  logic         load,
  input  logic [N-1:0] load_val,
  input  logic         shift_in,
  output logic [N-1:0] cells
);
  logic         lfsr_fb;
  logic [N-1:0] nx;

  assign lfsr_fb = ^(cells & TAPS);

  always_comb begin
    unique case (mode)
      OUT_TOGGLE: nx = ~cells;
      OUT_SHIFT:  nx = {cells[N-2:0], shift_in};
      OUT_LFSR:   nx = {cells[N-2:0], lfsr_fb};
      OUT_COUNT:  nx = cells + N'(1);
      default:    nx = cells;
    endcase
    if (load) nx = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cells <= '0;
    else        cells <= nx;
  end
endmodule

// File: rtl/bist_run_engine.sv
module bist_run_engine
  import bre_pkg::*;
#(
  parameter int                N_CELLS   = 8,
  parameter logic [N_CELLS-1:0]   MISR_TAPS = 8'hB8,
  parameter logic [2*N_CELLS-1:0] PRPG_TAPS = 16'hD008
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_en,
  input  logic               ctl_shift,
  input  logic               ctl_tdi,
  input  logic               ctl_update,
  output logic               ctl_tdo,
  input  logic               cell_load,
  input  logic [N_CELLS-1:0] load_in,
  input  logic [N_CELLS-1:0] load_out,
  input  logic [N_CELLS-1:0] in_pins,
  output logic [N_CELLS-1:0] in_cells,
  output logic [N_CELLS-1:0] out_cells
);
  localparam int CHAIN_W = 2 * N_CELLS;

  logic [OP_W-1:0] shift_q;
  logic [OP_W-1:0] op_q;
  in_mode_e        in_mode;
  out_mode_e       out_mode;
  logic            prpg_fb;

  bre_ctl_scan u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (ctl_shift),
    .tdi      (ctl_tdi),
    .update   (ctl_update),
    .tdo      (ctl_tdo),
    .shift_q  (shift_q),
    .op_q     (op_q)
  );

  assign prpg_fb = ^({out_cells, in_cells} & CHAIN_W'(PRPG_TAPS));

  always_comb begin
    in_mode  = IN_HOLD;
    out_mode = OUT_HOLD;
    if (run_en) begin
      case (op_q)
        OP_TOGGLE:   begin in_mode = IN_SAMPLE; out_mode = OUT_TOGGLE; end
        OP_PRPG:     begin in_mode = IN_SHIFT;  out_mode = OUT_SHIFT;  end
        OP_PSA:      begin in_mode = IN_MISR;   out_mode = OUT_HOLD;   end
        OP_PSA_PRPG: begin in_mode = IN_MISR;   out_mode = OUT_LFSR;   end
        OP_PSA_CNT:  begin in_mode = IN_MISR;   out_mode = OUT_COUNT;  end
        default:     begin in_mode = IN_HOLD;   out_mode = OUT_HOLD;   end
      endcase
    end
  end

  bre_in_group #(.N(N_CELLS), .TAPS(MISR_TAPS)) u_in (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (in_mode),
    .load     (cell_load),
    .load_val (load_in),
    .pins     (in_pins),
    .shift_in (prpg_fb),
    .cells    (in_cells)
  );

  bre_out_group #(.N(N_CELLS), .TAPS(MISR_TAPS)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (out_mode),
    .load     (cell_load),
    .load_val (load_out),
    .shift_in (in_cells[N_CELLS-1]),
    .cells    (out_cells)
  );
endmodule

// File: rtl/bre_checker.sv
module bre_checker #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run_en,
  input logic         cell_load,
  input logic         ctl_update,
  input logic [2:0]   shift_q,
  input logic [2:0]   op_q,
  input logic [N-1:0] load_in,
  input logic [N-1:0] load_out,
  input logic [N-1:0] in_cells,
  input logic [N-1:0] out_cells
);
  a_r2_update_commits: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_update |=> op_q == $past(shift_q));

  a_r2_op_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_update |=> $stable(op_q));

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !cell_load) |=> ($stable(in_cells) && $stable(out_cells)));

  a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !cell_load && op_q == 3'b000) |=> out_cells == ~$past(out_cells));

  a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !cell_load && op_q == 3'b010) |=> $stable(out_cells));

  a_r8_count: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !cell_load && op_q == 3'b100) |=> out_cells == N'($past(out_cells) + 1'b1));

  a_r9_unused_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !cell_load && op_q >= 3'b101) |=> ($stable(in_cells) && $stable(out_cells)));

  a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
    cell_load |=> (in_cells == $past(load_in) && out_cells == $past(load_out)));
endmodule

bind bist_run_engine bre_checker #(.N(8)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_en     (run_en),
  .cell_load  (cell_load),
  .ctl_update (ctl_update),
  .shift_q    (shift_q),
  .op_q       (op_q),
  .load_in    (load_in),
  .load_out   (load_out),
  .in_cells   (in_cells),
  .out_cells  (out_cells)
);

// File: tb/bist_run_engine_bench.sv
module bist_run_engine_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_en = 1'b0, ctl_shift = 1'b0, ctl_tdi = 1'b0, ctl_update = 1'b0;
  logic       cell_load = 1'b0;
  logic [7:0] load_in = '0, load_out = '0, in_pins = '0;
  logic       ctl_tdo;
  logic [7:0] in_cells, out_cells;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bist_run_engine u_bist_run_engine (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .ctl_shift(ctl_shift),
    .ctl_tdi(ctl_tdi), .ctl_update(ctl_update), .ctl_tdo(ctl_tdo),
    .cell_load(cell_load), .load_in(load_in), .load_out(load_out),
    .in_pins(in_pins), .in_cells(in_cells), .out_cells(out_cells)
  );

  // Behavioural reference model
  bit [7:0] m_in, m_out;
  bit [2:0] m_shift, m_op;
  string    m_tag = "R1";

  function automatic bit [7:0] misr_step(bit [7:0] s, bit [7:0] p);
    bit [7:0] r;
    r[0] = s[7] ^ s[5] ^ s[4] ^ s[3] ^ p[0];
    for (int i = 1; i < 8; i++) r[i] = s[i-1] ^ p[i];
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_in <= 0; m_out <= 0; m_shift <= 0; m_op <= 3'd7; m_tag <= "R1";
    end else begin
      bit [15:0] w;
      w = {m_out, m_in};
      if (ctl_update) m_op <= m_shift;
      if (ctl_shift) m_shift <= {ctl_tdi, m_shift[2], m_shift[1]};
      if (cell_load) begin
        m_in <= load_in; m_out <= load_out; m_tag <= "R10";
      end else if (!run_en) begin
        m_tag <= "R3";
      end else begin
        case (m_op)
          3'd0: begin m_in <= in_pins; m_out <= m_out ^ 8'hFF; m_tag <= "R4"; end
          3'd1: begin
            w = (w << 1) | 16'(w[15] ^ w[14] ^ w[12] ^ w[3]);
            m_out <= w[15:8]; m_in <= w[7:0]; m_tag <= "R5";
          end
          3'd2: begin m_in <= misr_step(m_in, in_pins); m_tag <= "R6"; end
          3'd3: begin
            m_in  <= misr_step(m_in, in_pins);
            m_out <= {m_out[6:0], m_out[7] ^ m_out[5] ^ m_out[4] ^ m_out[3]};
            m_tag <= "R7";
          end
          3'd4: begin
            m_in  <= misr_step(m_in, in_pins);
            m_out <= 8'((int'(m_out) + 1) % 256);
            m_tag <= "R8";
          end
          default: m_tag <= "R9";
        endcase
      end
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (in_cells !== m_in || out_cells !== m_out) begin
        bad++;
        $display("FAIL %s cells actual in=%h out=%h expected in=%h out=%h",
                 m_tag, in_cells, out_cells, m_in, m_out);
      end
      total++;
      if (ctl_tdo !== m_shift[0]) begin
        bad++;
        $display("FAIL R2 ctl_tdo actual=%b expected=%b", ctl_tdo, m_shift[0]);
      end
    end
  end

  task automatic load_op(input bit [2:0] code, input bit keep_run);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      run_en = keep_run; ctl_shift = 1'b1; ctl_tdi = code[i];
      in_pins = 8'($urandom);
    end
    @(negedge clk);
    ctl_shift = 1'b0; ctl_update = 1'b1;
    @(negedge clk);
    ctl_update = 1'b0;
  endtask

  task automatic seed(input bit [7:0] vi, input bit [7:0] vo, input bit with_run);
    @(negedge clk);
    run_en = with_run; cell_load = 1'b1; load_in = vi; load_out = vo;
    @(negedge clk);
    cell_load = 1'b0; run_en = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      run_en = 1'b1; in_pins = 8'($urandom);
    end
    @(negedge clk);
    run_en = 1'b0; in_pins = 8'($urandom);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    total++;
    if (in_cells !== 8'h00 || out_cells !== 8'h00 || ctl_tdo !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset actual in=%h out=%h tdo=%b expected 00 00 0",
               in_cells, out_cells, ctl_tdo);
    end
    // R9: reset code 111 holds while running
    seed(8'h5A, 8'hC3, 1'b0);
    run(6);
    for (int op = 0; op < 8; op++) begin
      load_op(3'(op), 1'b0);
      seed(8'h81 ^ 8'(op), (op == 4) ? 8'hF0 : 8'h3C, 1'b0);
      run(12);
      repeat (3) @(negedge clk);   // R3: paused, cells must hold
      run(24);                     // R8: count passes 255 -> 0 for op 4
    end
    // R2: shift a new code while counting; op must not change until update
    load_op(3'd4, 1'b0);
    seed(8'h11, 8'hFA, 1'b0);
    load_op(3'd0, 1'b1);
    run(8);
    // R10: load wins over a running step
    seed(8'hE7, 8'h19, 1'b1);
    run(4);
    repeat (2) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d cycles expected completion", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule